// File: doc/BRIEF.md
# Two-Symbol Quadruple Turing Engine

The block executes a Turing-machine program in hardware. The tape is a row of one-bit cells: 0 means blank and 1 means mark. A head pointer selects one cell. The program is held in a small table chosen at elaboration time. For every pair of state and scanned symbol, the table gives one action and a successor state. A start pulse loads the tape image, the head position and the initial state. After that, each clock with the step enable high performs one table lookup and exactly one action. Stepping stops when the successor state is the halt code or when the head would leave the tape.

Two programs are built in. Both add two unary numbers that lie on the tape as blocks of marks with one blank between them. Program 0 is a five-state adder: it fills the gap, walks to the right end, erases one mark and walks back to the leftmost mark. Program 1 is a four-state variant: it fills the gap, walks left, and then erases the first mark. The outputs are the tape contents, the head position, the current state, a halted flag, a fault flag and a saturating count of steps taken.

Top module: `tm_quad_engine`

## Requirements
- R1: While reset is held low and after its release, the outputs are as follows: tape all blank, head 0, state 0 (the halt code), halted 1, fault 0 and steps 0.
- R2: A start pulse does the following at the next edge:
  - loads tape, head and state from the load inputs;
  - clears steps and fault;
  - sets halted to 1 exactly when the loaded state is 0.
  Start takes priority over the step enable.
- R3: With step_en high, start low and halted 0, each clock edge performs exactly one action from the table entry indexed by {state, tape[head]}. The action codes are 00 = move right (head+1), 01 = move left (head-1), 10 = print (write 1 under the head) and 11 = erase (write 0). A move never alters the tape, and a write never moves the head. Tape bit i is cell i, and "right" means increasing index.
- R4: Each step loads the successor state from the same table entry. A successor of 0 still performs its action, then sets halted and leaves state at 0.
- R5: With step_en low, or with halted set, an edge without start changes none of tape, head, state or steps.
- R6: A move right at the last cell, or a move left at cell 0, sets fault and halted. That step leaves tape, head and state unchanged, and it is still counted.
- R7: steps rises by one per executed step and saturates at 2^CNT_W-1.
- R8: PROGRAM_SEL=0 (five-state adder). The tape holds m marks in cells 1..m and n marks in cells m+2..m+n+1, with head 1 and state 1.
  - For m>0, the run halts after 2m+2n+6 steps with marks exactly in cells 1..m+n and head 1.
  - For m=0, it halts after 1 step with the tape unchanged and head 2.
- R9: PROGRAM_SEL=1 (four-state adder). The starting configuration is the same as in R8. The run halts with marks exactly in cells 2..m+n+1 and head 2. It takes 2m+5 steps for m>0 and 1 step for m=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load pulse for tape, head and state |
| load_tape | input | TAPE_LEN | Initial tape image, bit i = cell i |
| load_head | input | $clog2(TAPE_LEN) | Initial head cell |
| load_state | input | 3 | Initial state, 0 = halt code |
| step_en | input | 1 | Execute one step this cycle |
| tape | output | TAPE_LEN | Current tape contents |
| head | output | $clog2(TAPE_LEN) | Current head cell |
| state | output | 3 | Current machine state |
| halted | output | 1 | Machine is stopped |
| fault | output | 1 | Head tried to leave the tape |
| steps | output | CNT_W | Saturating step count |

## Verification
A wrong table entry, or an action decoded wrongly, shows up within one step as a head that moved when a cell should have been written, or the reverse. Because the programs loop on their own output, such an error then shows up as a wrong final mark block, head cell or step total. The bench sweeps every addend pair up to 12+12 through both programs and compares the final tape, head and step count against closed-form expressions. A saturation instance and single-step probes catch off-by-one errors in the counter and in the edge handling on the first cycle where they matter.

// File: rtl/tm_quad_pkg.sv
package tm_quad_pkg;

  typedef enum logic [1:0] {
    ACT_RIGHT = 2'b00,
    ACT_LEFT  = 2'b01,
    ACT_PRINT = 2'b10,
    ACT_ERASE = 2'b11
  } act_e;

  localparam int STATE_W     = 3;
  localparam int ENTRY_W     = 2 + STATE_W;
  localparam int NUM_ENTRIES = 2 ** (STATE_W + 1);
  localparam int TABLE_W     = NUM_ENTRIES * ENTRY_W;

  localparam logic [STATE_W-1:0] ST_HALT = 3'd0;
  localparam logic [STATE_W-1:0] ST_Q1   = 3'd1;
  localparam logic [STATE_W-1:0] ST_Q2   = 3'd2;
  localparam logic [STATE_W-1:0] ST_Q3   = 3'd3;
  localparam logic [STATE_W-1:0] ST_Q4   = 3'd4;
  localparam logic [STATE_W-1:0] ST_Q5   = 3'd5;

  // Table slot for a (state, scanned symbol) pair.
  function automatic int slot(input logic [STATE_W-1:0] st, input logic sym);
    return int'({st, sym});
  endfunction

  function automatic logic [TABLE_W-1:0] put(input logic [TABLE_W-1:0] t,
                                             input logic [STATE_W-1:0] st,
                                             input logic sym, input act_e a,
                                             input logic [STATE_W-1:0] nxt);
    logic [TABLE_W-1:0] r;
    r = t;
    r[slot(st, sym)*ENTRY_W +: ENTRY_W] = {a, nxt};
    return r;
  endfunction

  // Unlisted slots default to all zero: move right, then halt.
  function automatic logic [TABLE_W-1:0] prog_table(input int sel);
    logic [TABLE_W-1:0] t;
    t = '0;
    t = put(t, ST_Q1, 1'b0, ACT_RIGHT, ST_HALT);
    t = put(t, ST_Q1, 1'b1, ACT_RIGHT, ST_Q2);
    t = put(t, ST_Q2, 1'b0, ACT_PRINT, ST_Q3);
    t = put(t, ST_Q2, 1'b1, ACT_RIGHT, ST_Q2);
    if (sel == 0) begin
      t = put(t, ST_Q3, 1'b0, ACT_LEFT,  ST_Q4);
      t = put(t, ST_Q3, 1'b1, ACT_RIGHT, ST_Q3);
      t = put(t, ST_Q4, 1'b0, ACT_LEFT,  ST_Q5);
      t = put(t, ST_Q4, 1'b1, ACT_ERASE, ST_Q4);
      t = put(t, ST_Q5, 1'b0, ACT_RIGHT, ST_HALT);
      t = put(t, ST_Q5, 1'b1, ACT_LEFT,  ST_Q5);
    end else begin
      t = put(t, ST_Q3, 1'b0, ACT_RIGHT, ST_Q4);
      t = put(t, ST_Q3, 1'b1, ACT_LEFT,  ST_Q3);
      t = put(t, ST_Q4, 1'b0, ACT_RIGHT, ST_HALT);
      t = put(t, ST_Q4, 1'b1, ACT_ERASE, ST_Q4);
    end
    return t;
  endfunction

endpackage

// File: rtl/tm_prog_rom.sv
module tm_prog_rom
  import tm_quad_pkg::*;
#(
  parameter int PROGRAM_SEL = 0
) (
  input  logic [STATE_W-1:0] cur_state,
  input  logic               scanned,
  output act_e               act,
  output logic [STATE_W-1:0] nxt_state
);

  localparam logic [TABLE_W-1:0] TABLE = prog_table(PROGRAM_SEL);

  logic [ENTRY_W-1:0] entries [NUM_ENTRIES];
  logic [ENTRY_W-1:0] picked;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    assign entries[e] = TABLE[e*ENTRY_W +: ENTRY_W];
  end

  assign picked    = entries[{cur_state, scanned}];
  assign act       = act_e'(picked[ENTRY_W-1 -: 2]);
  assign nxt_state = picked[STATE_W-1:0];

endmodule

// File: rtl/tm_tape.sv
module tm_tape
  import tm_quad_pkg::*;
#(
  parameter  int TAPE_LEN = 64,
  localparam int HEAD_W   = $clog2(TAPE_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [TAPE_LEN-1:0] load_tape,
  input  logic [HEAD_W-1:0]   load_head,
  input  logic                do_step,
  input  act_e                act,
  output logic [TAPE_LEN-1:0] tape,
  output logic [HEAD_W-1:0]   head,
  output logic                scanned,
  output logic                off_edge
);

  function automatic logic leaves_tape(input act_e a, input logic [HEAD_W-1:0] h);
    case (a)
      ACT_RIGHT: return h == HEAD_W'(TAPE_LEN - 1);
      ACT_LEFT:  return h == '0;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [HEAD_W-1:0] moved(input act_e a, input logic [HEAD_W-1:0] h);
    case (a)
      ACT_RIGHT: return h + 1'b1;
      ACT_LEFT:  return h - 1'b1;
      default:   return h;
    endcase
  endfunction

  logic cells [TAPE_LEN];
  logic apply;
  logic write_en;
  logic write_bit;

  assign scanned   = tape[head];
  assign off_edge  = leaves_tape(act, head);
  assign apply     = do_step && !off_edge;
  assign write_en  = apply && (act == ACT_PRINT || act == ACT_ERASE);
  assign write_bit = (act == ACT_PRINT);

  for (genvar c = 0; c < TAPE_LEN; c++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)                               cells[c] <= 1'b0;
      else if (load)                            cells[c] <= load_tape[c];
      else if (write_en && head == HEAD_W'(c))  cells[c] <= write_bit;
    end
    assign tape[c] = cells[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     head <= '0;
    else if (load)  head <= load_head;
    else if (apply) head <= moved(act, head);
  end

endmodule

// File: rtl/tm_step_ctr.sv
module tm_step_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= sat_inc(count);
  end

endmodule

// File: rtl/tm_quad_engine.sv
module tm_quad_engine
  import tm_quad_pkg::*;
#(
  parameter  int TAPE_LEN    = 64,
  parameter  int CNT_W       = 8,
  parameter  int PROGRAM_SEL = 0,
  localparam int HEAD_W      = $clog2(TAPE_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [TAPE_LEN-1:0] load_tape,
  input  logic [HEAD_W-1:0]   load_head,
  input  logic [STATE_W-1:0]  load_state,
  input  logic                step_en,
  output logic [TAPE_LEN-1:0] tape,
  output logic [HEAD_W-1:0]   head,
  output logic [STATE_W-1:0]  state,
  output logic                halted,
  output logic                fault,
  output logic [CNT_W-1:0]    steps
);

  // Named internal events, observed by the bound checker.
  logic               scanned;
  logic               off_edge;
  act_e               act;
  logic [STATE_W-1:0] nxt_state;
  logic               ev_step;
  logic               ev_fault;

  assign ev_step  = step_en && !halted && !start;
  assign ev_fault = ev_step && off_edge;

  tm_prog_rom #(.PROGRAM_SEL(PROGRAM_SEL)) u_rom (
    .cur_state (state),
    .scanned   (scanned),
    .act       (act),
    .nxt_state (nxt_state)
  );

  tm_tape #(.TAPE_LEN(TAPE_LEN)) u_tape (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_tape (load_tape),
    .load_head (load_head),
    .do_step   (ev_step),
    .act       (act),
    .tape      (tape),
    .head      (head),
    .scanned   (scanned),
    .off_edge  (off_edge)
  );

  tm_step_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .inc   (ev_step),
    .count (steps)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_HALT;
      halted <= 1'b1;
      fault  <= 1'b0;
    end else if (start) begin
      state  <= load_state;
      halted <= (load_state == ST_HALT);
      fault  <= 1'b0;
    end else if (ev_fault) begin
      halted <= 1'b1;
      fault  <= 1'b1;
    end else if (ev_step) begin
      state <= nxt_state;
      if (nxt_state == ST_HALT) halted <= 1'b1;
    end
  end

endmodule

// File: rtl/tm_quad_checker.sv
module tm_quad_checker
  import tm_quad_pkg::*;
#(
  parameter  int TAPE_LEN = 64,
  parameter  int CNT_W    = 8,
  localparam int HEAD_W   = $clog2(TAPE_LEN)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                step_en,
  input logic [TAPE_LEN-1:0] tape,
  input logic [HEAD_W-1:0]   head,
  input logic [STATE_W-1:0]  state,
  input logic                halted,
  input logic                fault,
  input logic [CNT_W-1:0]    steps,
  input logic                ev_step,
  input logic                ev_fault
);

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (steps == '0) && !fault);

  p_one_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && !ev_fault) |=> ($stable(tape) || $stable(head)));

  p_unit_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && !ev_fault) |=>
      ($stable(head) || head == $past(head) + 1'b1 || head == $past(head) - 1'b1));

  p_halt_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !fault) |-> state == ST_HALT);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && (!step_en || halted)) |=>
      ($stable(tape) && $stable(head) && $stable(state) && $stable(steps)));

  p_fault_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> halted);

  p_fault_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> (fault && $stable(head) && $stable(tape) && $stable(state)));

  p_no_decrease_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> steps >= $past(steps));

endmodule

bind tm_quad_engine tm_quad_checker #(.TAPE_LEN(TAPE_LEN), .CNT_W(CNT_W)) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .step_en  (step_en),
  .tape     (tape),
  .head     (head),
  .state    (state),
  .halted   (halted),
  .fault    (fault),
  .steps    (steps),
  .ev_step  (ev_step),
  .ev_fault (ev_fault)
);

// File: tb/tb_tm_quad_engine.sv
`timescale 1ns/1ps
module tb_tm_quad_engine;

  localparam int TL = 64;
  localparam int HW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [TL-1:0] load_tape;
  logic [HW-1:0] load_head;
  logic [2:0]    load_state;
  logic          step_en;

  logic [TL-1:0] tape0, tape1, tape2;
  logic [HW-1:0] head0, head1, head2;
  logic [2:0]    st0, st1, st2;
  logic          hlt0, hlt1, hlt2;
  logic          flt0, flt1, flt2;
  logic [7:0]    cnt0, cnt1;
  logic [3:0]    cnt2;

  int nvec = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  tm_quad_engine #(.TAPE_LEN(TL), .CNT_W(8), .PROGRAM_SEL(0)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .load_tape(load_tape),
    .load_head(load_head), .load_state(load_state), .step_en(step_en),
    .tape(tape0), .head(head0), .state(st0), .halted(hlt0), .fault(flt0),
    .steps(cnt0));

  tm_quad_engine #(.TAPE_LEN(TL), .CNT_W(8), .PROGRAM_SEL(1)) dut_alt (
    .clk(clk), .rst_n(rst_n), .start(start), .load_tape(load_tape),
    .load_head(load_head), .load_state(load_state), .step_en(step_en),
    .tape(tape1), .head(head1), .state(st1), .halted(hlt1), .fault(flt1),
    .steps(cnt1));

  tm_quad_engine #(.TAPE_LEN(TL), .CNT_W(4), .PROGRAM_SEL(0)) dut_sat (
    .clk(clk), .rst_n(rst_n), .start(start), .load_tape(load_tape),
    .load_head(load_head), .load_state(load_state), .step_en(step_en),
    .tape(tape2), .head(head2), .state(st2), .halted(hlt2), .fault(flt2),
    .steps(cnt2));

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [63:0] block(input int len, input int at);
    return ((64'd1 << len) - 64'd1) << at;
  endfunction

  function automatic logic [63:0] adder_tape(input int m, input int n);
    return block(m, 1) | block(n, m + 2);
  endfunction

  task automatic load(input logic [63:0] t, input int h, input int s, input logic en);
    @(negedge clk);
    start      = 1'b1;
    step_en    = en;
    load_tape  = t;
    load_head  = HW'(h);
    load_state = 3'(s);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_to_halt();
    step_en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      if (hlt0 && hlt1 && hlt2) break;
      @(negedge clk);
    end
    check("R4", "all instances halted", {61'd0, hlt0, hlt1, hlt2}, 64'd7);
    // Two extra enabled cycles after halting must change nothing (R5).
    @(negedge clk);
    @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic run_case(input int m, input int n);
    logic [63:0] t;
    int e0, e1;
    t  = adder_tape(m, n);
    e0 = (m > 0) ? 2*m + 2*n + 6 : 1;
    e1 = (m > 0) ? 2*m + 5 : 1;
    load(t, 1, 1, 1'b0);
    run_to_halt();
    // R8: five-state adder
    check("R8", "five-state tape", tape0, (m > 0) ? block(m + n, 1) : t);
    check("R8", "five-state head", 64'(head0), (m > 0) ? 64'd1 : 64'd2);
    check("R8", "five-state steps", 64'(cnt0), 64'(e0));
    check("R4", "five-state final state", 64'(st0), 64'd0);
    check("R6", "five-state no fault", 64'(flt0), 64'd0);
    // R9: four-state adder
    check("R9", "four-state tape", tape1, block(m + n, 2));
    check("R9", "four-state head", 64'(head1), 64'd2);
    check("R9", "four-state steps", 64'(cnt1), 64'(e1));
    // R7: 4-bit counter saturates at 15
    check("R7", "saturating steps", 64'(cnt2), 64'((e0 > 15) ? 15 : e0));
    check("R8", "saturating instance tape", tape2, tape0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nvec++;
    nbad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; step_en = 1'b0;
    load_tape = '0; load_head = '0; load_state = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: state after reset
    check("R1", "reset tape", tape0, 64'd0);
    check("R1", "reset head", 64'(head0), 64'd0);
    check("R1", "reset state", 64'(st0), 64'd0);
    check("R1", "reset halted", 64'(hlt0), 64'd1);
    check("R1", "reset fault", 64'(flt0), 64'd0);
    check("R1", "reset steps", 64'(cnt0), 64'd0);

    // R2: load of 2+3 configuration
    load(adder_tape(2, 3), 1, 1, 1'b0);
    check("R2", "loaded tape", tape0, adder_tape(2, 3));
    check("R2", "loaded head", 64'(head0), 64'd1);
    check("R2", "loaded state", 64'(st0), 64'd1);
    check("R2", "running after load", 64'(hlt0), 64'd0);

    // R3: single steps, move and write in separate cycles
    step_en = 1'b1; @(negedge clk); step_en = 1'b0;
    check("R3", "step1 head", 64'(head0), 64'd2);
    check("R3", "step1 state", 64'(st0), 64'd2);
    check("R3", "step1 tape", tape0, adder_tape(2, 3));
    step_en = 1'b1; @(negedge clk); @(negedge clk); step_en = 1'b0;
    check("R3", "print head stays", 64'(head0), 64'd3);
    check("R3", "print writes mark", tape0, adder_tape(2, 3) | 64'd8);
    check("R4", "state after print", 64'(st0), 64'd3);
    check("R7", "three steps", 64'(cnt0), 64'd3);

    // R5: enable low freezes everything
    repeat (3) @(negedge clk);
    check("R5", "idle head", 64'(head0), 64'd3);
    check("R5", "idle tape", tape0, adder_tape(2, 3) | 64'd8);
    check("R5", "idle steps", 64'(cnt0), 64'd3);
    check("R5", "idle state", 64'(st0), 64'd3);

    // R2: start wins over step_en mid-run
    load(adder_tape(1, 1), 1, 1, 1'b1);
    check("R2", "priority steps cleared", 64'(cnt0), 64'd0);
    check("R2", "priority head", 64'(head0), 64'd1);
    check("R2", "priority state", 64'(st0), 64'd1);
    check("R2", "priority tape", tape0, adder_tape(1, 1));
    run_to_halt();
    check("R8", "1+1 steps", 64'(cnt0), 64'd10);

    // R2/R5: loading the halt code stops at once
    load(64'h5, 5, 0, 1'b0);
    check("R2", "halt-code load halted", 64'(hlt0), 64'd1);
    step_en = 1'b1; @(negedge clk); @(negedge clk); step_en = 1'b0;
    check("R5", "halted head unchanged", 64'(head0), 64'd5);
    check("R5", "halted steps unchanged", 64'(cnt0), 64'd0);

    // R6: right edge, state 2 over all marks from cell 60
    load({64{1'b1}}, 60, 2, 1'b0);
    run_to_halt();
    check("R6", "right fault flag", 64'(flt0), 64'd1);
    check("R6", "right fault head", 64'(head0), 64'd63);
    check("R6", "right fault state", 64'(st0), 64'd2);
    check("R6", "right fault steps", 64'(cnt0), 64'd4);
    check("R6", "right fault tape", tape0, {64{1'b1}});

    // R6: left edge, state 5 over marks in cells 0..3 from cell 3
    load(64'hF, 3, 5, 1'b0);
    run_to_halt();
    check("R6", "left fault flag", 64'(flt0), 64'd1);
    check("R6", "left fault head", 64'(head0), 64'd0);
    check("R6", "left fault state", 64'(st0), 64'd5);
    check("R6", "left fault steps", 64'(cnt0), 64'd4);
    check("R6", "left fault tape", tape0, 64'hF);

    // R2: a new start clears the fault
    load(adder_tape(0, 0), 1, 1, 1'b0);
    check("R2", "fault cleared by start", 64'(flt0), 64'd0);

    // R8, R9, R7: sweep of all addend pairs up to 12+12
    for (int m = 0; m <= 12; m++) begin
      for (int n = 0; n <= 12; n++) begin
        run_case(m, n);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule